// File: doc/BRIEF.md
# Branch Condition and Link Unit

This unit decides, in a single execution cycle, where a 32-bit processor fetches next after a branch instruction. It receives the instruction word, two general register values read by the register file (one that is tested, one that holds the branch target) and the incremented fetch address. It returns the next PC, a taken flag and a link write for the branch-and-link form. The unit is purely combinational. The register file and the PC register stay outside it.

The condition does not come from flags. A 3-bit code in the lowest instruction bits picks a test on the tested register: whether it is zero, and what its top (sign) bit is. With the linking opcode, the return address is always written, even when the branch is not taken.

Top module: `branch_link_unit`

## Requirements
- R1: The condition code is instruction bits 2..0. Code 0 never takes the branch.
- R2: Code 1 always takes the branch.
- R3: Code 2 takes the branch when the tested register equals zero. Code 3 takes it when the tested register is nonzero.
- R4: Code 4 takes the branch when bit 31 of the tested register is 0. Code 5 takes it when that bit is 1.
- R5: Codes 6 and 7 never take the branch.
- R6: The opcode is instruction bits 31..27. For opcode 8 (plain branch), next_pc equals the target register value when the condition holds and equals pc_plus4 otherwise. link_we stays 0.
- R7: For opcode 9 (branch and link), link_we is 1 whatever the condition. link_data equals pc_plus4 and link_reg equals instruction bits 26..22. next_pc follows the same rule as opcode 8.
- R8: For any opcode other than 8 and 9, taken and link_we are both 0 and next_pc equals pc_plus4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| test_val | input | 32 | Value of the register being tested |
| target_val | input | 32 | Value of the register holding the branch target |
| pc_plus4 | input | 32 | Fetch address plus 4 |
| taken | output | 1 | Branch is taken this cycle |
| next_pc | output | 32 | Address to load into the PC |
| link_we | output | 1 | Write enable for the return-address write |
| link_reg | output | 5 | Register index that receives the return address |
| link_data | output | 32 | Return address to write |

## Verification
The bench sweeps all eight condition codes for both branch opcodes and for non-branch opcodes. The tested values are zero, small and largest positive values, the most negative value and all-ones.

The most likely bugs each show up in this sweep:
- A sign test that reads the wrong bit mis-handles 0x8000_0000 or 0x7FFF_FFFF.
- A design that gates the link write with the condition drops the link on not-taken opcode-9 cases.
- Decoding codes 6 and 7 as aliases of lower codes makes them taken for some values.
- A non-branch opcode that carries a branch-like low field gives a taken result or a redirected next_pc.

// File: rtl/branch_link_unit.sv
module branch_link_unit #(
  parameter int XLEN      = 32,
  parameter int REG_BITS  = 5,
  parameter int OP_BITS   = 5,
  parameter int CODE_BITS = 3,
  parameter logic [OP_BITS-1:0] OP_BR  = 5'd8,
  parameter logic [OP_BITS-1:0] OP_BRL = 5'd9
) (
  input  logic [XLEN-1:0]     instr,
  input  logic [XLEN-1:0]     test_val,
  input  logic [XLEN-1:0]     target_val,
  input  logic [XLEN-1:0]     pc_plus4,
  output logic                taken,
  output logic [XLEN-1:0]     next_pc,
  output logic                link_we,
  output logic [REG_BITS-1:0] link_reg,
  output logic [XLEN-1:0]     link_data
);
  localparam int OP_LSB = XLEN - OP_BITS;
  localparam int RA_LSB = OP_LSB - REG_BITS;

  logic [OP_BITS-1:0]   op;
  logic [CODE_BITS-1:0] code;
  logic                 is_br, is_brl, cond_ok, is_zero, is_neg;

  assign op      = instr[XLEN-1:OP_LSB];
  assign code    = instr[CODE_BITS-1:0];
  assign is_br   = (op == OP_BR);
  assign is_brl  = (op == OP_BRL);
  assign is_zero = (test_val == '0);
  assign is_neg  = test_val[XLEN-1];

  always_comb begin
    case (code)
      3'd1:    cond_ok = 1'b1;
      3'd2:    cond_ok = is_zero;
      3'd3:    cond_ok = !is_zero;
      3'd4:    cond_ok = !is_neg;
      3'd5:    cond_ok = is_neg;
      default: cond_ok = 1'b0;
    endcase
  end

  assign taken     = (is_br || is_brl) && cond_ok;
  assign next_pc   = taken ? target_val : pc_plus4;
  assign link_we   = is_brl;
  assign link_reg  = instr[RA_LSB +: REG_BITS];
  assign link_data = pc_plus4;

  always_comb begin
    if (code == 3'd0) AST_NEVER_CODE: assert (!taken);                       // R1
    if ((is_br || is_brl) && code == 3'd1) AST_ALWAYS_CODE: assert (taken);  // R2
    if (code[2:1] == 2'b11) AST_SPARE_CODES: assert (!taken);                // R5
    if (!(is_br || is_brl)) AST_NON_BRANCH_QUIET: assert (!taken && !link_we && next_pc == pc_plus4); // R8
    if (link_we) AST_LINK_RETURN: assert (link_data == pc_plus4);            // R7
    if (!taken) AST_FALL_THROUGH: assert (next_pc == pc_plus4);              // R6
  end
endmodule

// File: tb/sim_branch_link_unit.sv
module sim_branch_link_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr, test_val, target_val, pc_plus4;
  logic        taken, link_we;
  logic [31:0] next_pc, link_data;
  logic [4:0]  link_reg;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  branch_link_unit u0 (
    .instr(instr), .test_val(test_val), .target_val(target_val),
    .pc_plus4(pc_plus4), .taken(taken), .next_pc(next_pc),
    .link_we(link_we), .link_reg(link_reg), .link_data(link_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (instr=%h test=%h)", req, act, exp, instr, test_val);
    end
  endtask

  function automatic bit cond_of(input int code, input logic [31:0] v);
    case (code)
      1: return 1'b1;
      2: return v == 32'd0;
      3: return v != 32'd0;
      4: return v[31] == 1'b0;
      5: return v[31] == 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(input int code);
    case (code)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4, 5: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [5];
    int ops [6];
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0005; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF;
    ops[0] = 8; ops[1] = 9; ops[2] = 0; ops[3] = 12; ops[4] = 31; ops[5] = 10;

    instr = '0; test_val = '0; target_val = 32'h0000_4000; pc_plus4 = 32'h0000_0104;
    @(negedge clk);
    chk("R8 idle taken", {31'd0, taken}, 32'd0);
    chk("R8 idle link_we", {31'd0, link_we}, 32'd0);
    chk("R8 idle next_pc", next_pc, 32'h0000_0104);

    for (int o = 0; o < 6; o++) begin
      for (int c = 0; c < 8; c++) begin
        for (int v = 0; v < 5; v++) begin
          bit br, exp_t;
          logic [4:0] ra;
          @(posedge clk);
          ra = 5'((o * 7 + c * 3 + v) % 32);
          instr = {5'(ops[o]), ra, 5'(v + 1), 5'(c + 2), 9'(o * 13), 3'(c)};
          test_val = vals[v];
          target_val = 32'hA000_0000 + 32'(o * 256 + c * 16 + v * 4);
          pc_plus4 = 32'h0001_0000 + 32'(o * 1024 + c * 64 + v * 8 + 4);
          @(negedge clk);
          br = (ops[o] == 8) || (ops[o] == 9);
          exp_t = br && cond_of(c, vals[v]);
          if (br) begin
            chk({req_of(c), " taken"}, {31'd0, taken}, {31'd0, exp_t});
            chk(ops[o] == 8 ? "R6 next_pc" : "R7 next_pc", next_pc, exp_t ? target_val : pc_plus4);
            if (ops[o] == 8) chk("R6 link_we", {31'd0, link_we}, 32'd0);
            else begin
              chk("R7 link_we", {31'd0, link_we}, 32'd1);
              chk("R7 link_data", link_data, pc_plus4);
              chk("R7 link_reg", {27'd0, link_reg}, {27'd0, ra});
            end
          end else begin
            chk("R8 taken", {31'd0, taken}, 32'd0);
            chk("R8 link_we", {31'd0, link_we}, 32'd0);
            chk("R8 next_pc", next_pc, pc_plus4);
          end
        end
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule